// File: doc/BRIEF.md
# Identification Read and Deep Sleep Responder

This block sits behind the command decoder of a serial flash slave and serves three housekeeping commands. The first reads back identification: a fixed four-byte string giving the maker code, two device code bytes and the length of an extended information string. The second puts the device into deep sleep. The third wakes it up again. The decoder supplies one-cycle strobes for the chip-select falling and rising edges, a strobe carrying each fully received opcode, and a byte strobe each time the shift register wants the next output byte. The block returns the current output byte and a sleep flag that gates the rest of the device.

A sleep request only takes effect once its opcode has been received in full and the frame is closed by chip-select rising. It is refused while the device reports an internal operation in progress. While asleep, every opcode except wake is dropped. A wake frame starts a configurable count of clock cycles, and the sleep flag falls when the count runs out. A wake frame cut short before its opcode completes leaves the device asleep.

Top module: `id_pd_responder`

## Requirements
- R1: After reset `pwr_down` is 0, `so_active` is 0 and `so_data` is 00h.
- R2: After an opcode strobe carrying 9Fh while awake, `so_data` holds 1Fh in the following cycle. Each `byte_stb` then advances to the next byte. The full order is 1Fh, 47h, 00h, 00h, and `so_active` is 1 while the string is being served.
- R3: The second byte has family code 010 in bits 7:5 and density code 00111 in bits 4:0.
- R4: A `byte_stb` given after the last byte keeps `so_data` at 00h with `so_active` still 1.
- R5: A `cs_rise` strobe ends the string: from the next cycle `so_active` is 0. Whenever `so_active` is 0, `so_data` is 00h. A `cs_rise` in the same cycle as `byte_stb` takes priority.
- R6: An opcode strobe carrying B9h while awake and not busy, followed by `cs_rise`, sets `pwr_down` to 1 in the cycle after the `cs_rise` strobe, and only then.
- R7: A B9h opcode given while `busy` is 1 is ignored. A frame with no complete opcode changes nothing.
- R8: While `pwr_down` is 1, a 9Fh opcode is ignored: `so_active` stays 0.
- R9: An opcode strobe carrying ABh while asleep, followed by `cs_rise`, clears `pwr_down` exactly WAKE_CYC cycles after the `cs_rise` strobe.
- R10: A frame closed while asleep with no complete ABh opcode leaves `pwr_down` at 1.
- R11: An ABh frame while awake has no effect, and the responder still serves the identification string afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_fall | input | 1 | One-cycle strobe marking the start of a frame |
| cs_rise | input | 1 | One-cycle strobe marking the end of a frame |
| op_stb | input | 1 | A full opcode has been received |
| op_code | input | 8 | Opcode value, valid with `op_stb` |
| byte_stb | input | 1 | Shift register requests the next output byte |
| busy | input | 1 | Device is in an internal program or erase operation |
| so_data | output | 8 | Byte to shift out |
| so_active | output | 1 | Identification string is being served |
| pwr_down | output | 1 | Device is in deep sleep |

## Verification
The two functions that can meet in one cycle are advancing the identification string and closing the frame. This happens when the decoder raises `byte_stb` in the same cycle as `cs_rise`. The bench provokes this by driving both strobes together in the middle of a string. It judges the result by requiring `so_active` to be 0 and `so_data` to be 00h in the next cycle, rather than the next byte appearing. A second overlap, a sleep request while `busy` is high, is judged by `pwr_down` staying 0 after the frame closes.

// File: rtl/id_pd_responder.sv
module id_pd_responder #(
  parameter int          WAKE_CYC = 8,
  parameter logic [7:0]  OP_ID    = 8'h9F,
  parameter logic [7:0]  OP_SLEEP = 8'hB9,
  parameter logic [7:0]  OP_WAKE  = 8'hAB,
  parameter logic [7:0]  MFR_ID   = 8'h1F,
  parameter logic [7:0]  DEV_ID1  = 8'h47,
  parameter logic [7:0]  DEV_ID2  = 8'h00,
  parameter logic [7:0]  EXT_LEN  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_fall,
  input  logic       cs_rise,
  input  logic       op_stb,
  input  logic [7:0] op_code,
  input  logic       byte_stb,
  input  logic       busy,
  output logic [7:0] so_data,
  output logic       so_active,
  output logic       pwr_down
);
  localparam int NBYTES = 4;
  localparam int IW = $clog2(NBYTES + 1);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic          streaming, sleep_arm, wake_arm, waking;
  logic [IW-1:0] idx;
  logic [CW-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streaming <= 1'b0;
      sleep_arm <= 1'b0;
      wake_arm  <= 1'b0;
      waking    <= 1'b0;
      pwr_down  <= 1'b0;
      idx       <= '0;
      wcnt      <= '0;
    end else begin
      if (cs_fall) begin
        streaming <= 1'b0;
        sleep_arm <= 1'b0;
        wake_arm  <= 1'b0;
      end
      if (op_stb && !waking) begin
        if (!pwr_down) begin
          if (op_code == OP_ID) begin
            streaming <= 1'b1;
            idx       <= '0;
          end
          if (op_code == OP_SLEEP && !busy) sleep_arm <= 1'b1;
        end else if (op_code == OP_WAKE) begin
          wake_arm <= 1'b1;
        end
      end
      if (byte_stb && streaming && !cs_rise && idx != IW'(NBYTES))
        idx <= idx + IW'(1);
      if (cs_rise) begin
        streaming <= 1'b0;
        sleep_arm <= 1'b0;
        wake_arm  <= 1'b0;
        if (sleep_arm) pwr_down <= 1'b1;
        if (wake_arm) begin
          waking <= 1'b1;
          wcnt   <= CW'(WAKE_CYC);
        end
      end
      if (waking) begin
        wcnt <= wcnt - CW'(1);
        if (wcnt == CW'(1)) begin
          waking   <= 1'b0;
          pwr_down <= 1'b0;
        end
      end
    end
  end

  logic [7:0] id_byte;
  always_comb begin
    case (idx)
      IW'(0):  id_byte = MFR_ID;
      IW'(1):  id_byte = DEV_ID1;
      IW'(2):  id_byte = DEV_ID2;
      IW'(3):  id_byte = EXT_LEN;
      default: id_byte = 8'h00;
    endcase
  end

  assign so_active = streaming;
  assign so_data   = streaming ? id_byte : 8'h00;
endmodule

// File: rtl/id_pd_responder_chk.sv
module id_pd_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_fall,
  input logic       cs_rise,
  input logic       op_stb,
  input logic       byte_stb,
  input logic [7:0] so_data,
  input logic       so_active,
  input logic       pwr_down
);
  assert_sleep_on_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $past(cs_rise));

  assert_asleep_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !so_active);

  assert_close_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !so_active);

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !so_active |-> so_data == 8'h00);

  assert_hold_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (so_active && !byte_stb && !cs_rise && !cs_fall && !op_stb) |=> $stable(so_data));
endmodule

bind id_pd_responder id_pd_responder_chk u_chk (.*);

// File: tb/id_pd_responder_bench.sv
`timescale 1ns/1ps
module id_pd_responder_bench;
  localparam int WAKE = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_fall = 0, cs_rise = 0, op_stb = 0, byte_stb = 0, busy = 0;
  logic [7:0] op_code = 8'h00;
  logic [7:0] so_data;
  logic so_active, pwr_down;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  id_pd_responder #(.WAKE_CYC(WAKE)) u_id_pd_responder (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .op_stb(op_stb), .op_code(op_code), .byte_stb(byte_stb), .busy(busy),
    .so_data(so_data), .so_active(so_active), .pwr_down(pwr_down));

  // Monitor: pops expected bytes and compares them with the design's output.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (so_data !== e.val || so_active !== 1'b1) begin
        n_fail++;
        $display("FAIL %s: so_data=%02h active=%b expected %02h active=1",
                 e.req, so_data, so_active, e.val);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    cs_fall = 0; cs_rise = 0; op_stb = 0; byte_stb = 0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    @(negedge clk);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic frame_op(input logic [7:0] op);
    cs_fall = 1; step();
    op_stb = 1; op_code = op; step();
  endtask

  task automatic close();
    cs_rise = 1; step();
  endtask

  // Driver for an identification read of nb bytes.
  task automatic read_id(input int nb, input string req);
    logic [7:0] idv [4];
    idv = '{8'h1F, 8'h47, 8'h00, 8'h00};
    frame_op(8'h9F);
    exp_q.push_back('{idv[0], req});
    for (int i = 1; i < nb; i++) begin
      byte_stb = 1; step();
      exp_q.push_back('{(i < 4) ? idv[i] : 8'h00, req});
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 pwr_down", {7'b0, pwr_down}, 8'h00);
    chk("R1 so_active", {7'b0, so_active}, 8'h00);
    chk("R1 so_data", so_data, 8'h00);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    step();

    // R2 / R4: full string plus two extra bytes
    read_id(6, "R2/R4 id stream");
    @(negedge clk);
    chk("R4 active past end", {7'b0, so_active}, 8'h01);
    close();
    chk("R5 closed", {7'b0, so_active}, 8'h00);
    chk("R5 data idle", so_data, 8'h00);

    // R3: fields of the second byte
    frame_op(8'h9F);
    byte_stb = 1; step();
    chk("R3 family", {5'b0, so_data[7:5]}, 8'h02);
    chk("R3 density", {3'b0, so_data[4:0]}, 8'h07);
    // R5: close and byte strobe in the same cycle
    cs_rise = 1; byte_stb = 1; step();
    chk("R5 overlap active", {7'b0, so_active}, 8'h00);
    chk("R5 overlap data", so_data, 8'h00);

    // R7: sleep while busy, and an empty frame
    busy = 1; frame_op(8'hB9); close(); busy = 0;
    chk("R7 busy refused", {7'b0, pwr_down}, 8'h00);
    cs_fall = 1; step(); close();
    chk("R7 empty frame", {7'b0, pwr_down}, 8'h00);

    // R11: wake while awake
    frame_op(8'hAB); close();
    repeat (WAKE + 1) step();
    chk("R11 wake while awake", {7'b0, pwr_down}, 8'h00);
    read_id(2, "R11 id after stray wake");
    close();

    // R6: enter sleep
    frame_op(8'hB9);
    chk("R6 not before close", {7'b0, pwr_down}, 8'h00);
    close();
    chk("R6 asleep", {7'b0, pwr_down}, 8'h01);

    // R8: id ignored while asleep
    frame_op(8'h9F);
    chk("R8 id ignored", {7'b0, so_active}, 8'h00);
    close();

    // R10: truncated wake frame
    cs_fall = 1; step(); close();
    repeat (WAKE + 1) step();
    chk("R10 still asleep", {7'b0, pwr_down}, 8'h01);

    // R9: wake timing
    frame_op(8'hAB); close();
    for (int i = 1; i < WAKE; i++) begin
      step();
      chk("R9 waking", {7'b0, pwr_down}, 8'h01);
    end
    step();
    chk("R9 awake", {7'b0, pwr_down}, 8'h00);
    read_id(4, "R9 id after wake");
    close();

    repeat (3) step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule